// File: doc/BRIEF.md
# Oversampling Touch-ADC Scan Sequencer

The block controls a serial touchscreen converter over an SPI link in mode 0. A start pulse launches a scan over the channels selected by an 8-bit enable mask. For each selected channel the sequencer sends a group of 24-bit frames. Each frame is a command byte followed by a 16-bit reply. The first few frames of a group let the analog input settle and are thrown away. The replies that follow are summed and divided by their count, rounding up, to give one 12-bit result for the channel.

All groups of one scan go out back to back inside a single chip-select window. Each channel's result is written to its own output slot and marked by a one-cycle valid strobe. A done pulse closes the scan. The settling count and the averaging count are per-channel inputs, latched when the scan starts. The SPI clock rate is set by one parameter, which gives the number of system clocks per half period.

Top module: `tsc_scan_seq`

## Requirements
- R1: Every command byte has bit 7 = 1, the channel address in bits 6:4 and bit 3 = 0. Bits 2 and 1 are both 1 for addresses 0, 2, 6 and 7 and both 0 for addresses 1, 3, 4 and 5.
- R2: Command bit 0 is 1 on every frame of a channel group except the last frame of that group, where it is 0.
- R3: A group has (settling count + averaging count) frames. Groups are sent only for enabled channels, in ascending address order, and a scan contains no other frames.
- R4: A channel's result is the sum of reply bits 14:3 over the frames after the first settling-count frames, divided by the averaging count and rounded up.
- R5: An averaging count of 0 is handled as 1.
- R6: Each enabled channel raises its valid bit for exactly one cycle per scan, in the cycle its result slot takes the new value. A disabled channel gets no strobe and its result slot keeps its old value.
- R7: Done is a single-cycle pulse. In a non-empty scan it coincides with the last enabled channel's strobe, with chip select already high. For an empty mask, done comes in the cycle after start and chip select never falls.
- R8: The SPI clock idles low and is low whenever chip select is high. Chip select goes low before the first frame, stays low between frames and rises once, after the last frame. A frame has 24 rising clock edges, and data are shifted MSB first.
- R9: A start received during a scan is ignored. A start received in the cycle that done is high begins a new scan.
- R10: After reset, chip select is high, SPI clock and data out are low, and done, all valid bits and all result slots are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Scan launch pulse |
| ch_en | input | NCH | Channel enable mask, bit i = address i |
| skip_cnt | input | NCH*CNT_W | Settling frame count per channel, slot i at bits i*CNT_W |
| ovs_cnt | input | NCH*CNT_W | Averaging frame count per channel, slot i at bits i*CNT_W |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Command data to the converter |
| spi_miso | input | 1 | Reply data from the converter |
| result | output | NCH*12 | Averaged results, slot i at bits i*12 |
| result_vld | output | NCH | One-cycle strobe per channel result |
| done | output | 1 | Scan completion pulse |

## Verification
Two events share one cycle: the valid strobe of the highest enabled channel and the done pulse. A start can land in that same cycle, and it must be taken as a new scan, not dropped. The bench starts every other scan of its mask sweep in the exact cycle it sees done. It checks that the later scan's frame log, result values and strobes are as correct as those of a scan started from idle. It also checks that the earlier scan's strobes and done were counted in full. In some scans the bench also sends a stray start in the middle of the scan, with the mask inverted. The frame count and the command sequence then show that the stray start was ignored.

// File: rtl/tsc_scan_pkg.sv
package tsc_scan_pkg;

  localparam int ADDR_W  = 3;
  localparam int CMD_W   = 8;
  localparam int RSP_W   = 16;
  localparam int FRAME_W = CMD_W + RSP_W;
  localparam int RES_W   = 12;
  localparam int RES_LSB = 3;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_XFER,
    SQ_DIV
  } sq_state_e;

  // channels whose conversion needs the internal reference, single ended
  function automatic logic needs_ref(input logic [ADDR_W-1:0] addr);
    needs_ref = (addr == 3'd0) || (addr == 3'd2) || (addr == 3'd6) || (addr == 3'd7);
  endfunction

  function automatic logic [CMD_W-1:0] make_cmd(input logic [ADDR_W-1:0] addr,
                                                input logic             keep_on);
    logic r;
    r = needs_ref(addr);
    make_cmd = {1'b1, addr, 1'b0, r, r, keep_on};
  endfunction

endpackage

// File: rtl/tsc_spi_frame.sv
module tsc_spi_frame
  import tsc_scan_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CMD_W-1:0] cmd,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             active,
  output logic             fdone,
  output logic [RSP_W-1:0] rsp
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  logic             active_q, active_d;
  logic             sclk_q, sclk_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [CMD_W-1:0] tx_q, tx_d;
  logic [RSP_W-1:0] rx_q, rx_d;
  logic             fdone_q, fdone_d;
  logic             tick;

  assign tick = active_q && (div_q == DIV_LAST);

  always_comb begin
    active_d = active_q;
    sclk_d   = sclk_q;
    div_d    = div_q;
    bit_d    = bit_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    fdone_d  = 1'b0;
    if (go && !active_q) begin
      active_d = 1'b1;
      sclk_d   = 1'b0;
      div_d    = '0;
      bit_d    = '0;
      tx_d     = cmd;
    end else if (active_q) begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (!sclk_q) begin
          // rising edge: capture reply bit
          sclk_d = 1'b1;
          rx_d   = {rx_q[RSP_W-2:0], miso};
        end else begin
          // falling edge: advance command bit or close the frame
          sclk_d = 1'b0;
          if (bit_q == BIT_LAST) begin
            active_d = 1'b0;
            fdone_d  = 1'b1;
          end else begin
            bit_d = bit_q + 1'b1;
            tx_d  = {tx_q[CMD_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      fdone_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      sclk_q   <= sclk_d;
      div_q    <= div_d;
      bit_q    <= bit_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      fdone_q  <= fdone_d;
    end
  end

  assign sclk   = sclk_q;
  assign mosi   = active_q & tx_q[CMD_W-1];
  assign active = active_q;
  assign fdone  = fdone_q;
  assign rsp    = rx_q;

endmodule

// File: rtl/tsc_ceil_div.sv
module tsc_ceil_div #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);

  localparam int WK   = NUM_W + 1;
  localparam int CNTW = $clog2(WK + 1);

  logic            run_q, run_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [WK-1:0]   dvd_q, dvd_d;
  logic [DEN_W:0]  rem_q, rem_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic            done_q, done_d;
  logic [DEN_W:0]  rem_sh;
  logic            fits;

  assign rem_sh = {rem_q[DEN_W-1:0], dvd_q[WK-1]};
  assign fits   = rem_sh >= {1'b0, den_q};

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    dvd_d  = dvd_q;
    rem_d  = rem_q;
    den_d  = den_q;
    done_d = 1'b0;
    if (go) begin
      // bias the dividend so the floor quotient becomes the ceiling
      dvd_d = WK'(num) + WK'(den) - 1'b1;
      den_d = den;
      rem_d = '0;
      cnt_d = CNTW'(WK);
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
      dvd_d = {dvd_q[WK-2:0], fits};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNTW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      dvd_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      dvd_q  <= dvd_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign quo  = dvd_q[NUM_W-1:0];

endmodule

// File: rtl/tsc_first_set.sv
module tsc_first_set #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign found = |vec;

endmodule

// File: rtl/tsc_scan_seq.sv
module tsc_scan_seq
  import tsc_scan_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int CNT_W     = 4,
  parameter int SCLK_HALF = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NCH-1:0]       ch_en,
  input  logic [NCH*CNT_W-1:0] skip_cnt,
  input  logic [NCH*CNT_W-1:0] ovs_cnt,
  output logic                 spi_sclk,
  output logic                 spi_cs_n,
  output logic                 spi_mosi,
  input  logic                 spi_miso,
  output logic [NCH*RES_W-1:0] result,
  output logic [NCH-1:0]       result_vld,
  output logic                 done
);

  localparam int IDX_W = ADDR_W;
  localparam int FR_W  = CNT_W + 1;
  localparam int SUM_W = RES_W + CNT_W;

  sq_state_e            st_q, st_d;
  logic [NCH-1:0]       mask_q, mask_d;
  logic [NCH*CNT_W-1:0] skip_q, skip_d;
  logic [NCH*CNT_W-1:0] ovs_q, ovs_d;
  logic [IDX_W-1:0]     cur_q, cur_d;
  logic [FR_W-1:0]      fidx_q, fidx_d;
  logic [SUM_W-1:0]     acc_q, acc_d;
  logic                 go_q, go_d;
  logic                 cs_n_q, cs_n_d;
  logic                 div_go_q, div_go_d;
  logic [SUM_W-1:0]     div_num_q, div_num_d;
  logic [NCH*RES_W-1:0] res_q, res_d;
  logic [NCH-1:0]       vld_q, vld_d;
  logic                 done_q, done_d;

  logic [CNT_W-1:0] cur_skip, cur_ovs_raw, cur_ovs;
  logic [FR_W-1:0]  nfr;
  logic             last_fr, keep_smp;
  logic [SUM_W-1:0] acc_sum;
  logic [NCH-1:0]   higher;
  logic             found_all, found_hi;
  logic [IDX_W-1:0] idx_all, idx_hi;

  logic             frm_active, frm_done;
  logic [CMD_W-1:0] frm_cmd;
  logic [RSP_W-1:0] frm_rsp;
  logic             div_done;
  logic [SUM_W-1:0] div_quo;

  assign cur_skip    = skip_q[cur_q*CNT_W +: CNT_W];
  assign cur_ovs_raw = ovs_q[cur_q*CNT_W +: CNT_W];
  assign cur_ovs     = (cur_ovs_raw == '0) ? CNT_W'(1) : cur_ovs_raw;
  assign nfr         = FR_W'(cur_skip) + FR_W'(cur_ovs);
  assign last_fr     = (fidx_q == nfr - 1'b1);
  assign keep_smp    = fidx_q >= FR_W'(cur_skip);
  assign acc_sum     = acc_q + (keep_smp ? SUM_W'(frm_rsp[RES_LSB +: RES_W]) : '0);
  assign frm_cmd     = make_cmd(cur_q, !last_fr);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      higher[i] = mask_q[i] && (IDX_W'(i) > cur_q);
    end
  end

  tsc_first_set #(.N(NCH), .IW(IDX_W)) u_first_all (
    .vec   (ch_en),
    .found (found_all),
    .idx   (idx_all)
  );

  tsc_first_set #(.N(NCH), .IW(IDX_W)) u_first_hi (
    .vec   (higher),
    .found (found_hi),
    .idx   (idx_hi)
  );

  tsc_spi_frame #(.HALF_DIV(SCLK_HALF)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go_q),
    .cmd    (frm_cmd),
    .miso   (spi_miso),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi),
    .active (frm_active),
    .fdone  (frm_done),
    .rsp    (frm_rsp)
  );

  tsc_ceil_div #(.NUM_W(SUM_W), .DEN_W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go_q),
    .num   (div_num_q),
    .den   (cur_ovs),
    .done  (div_done),
    .quo   (div_quo)
  );

  always_comb begin
    st_d      = st_q;
    mask_d    = mask_q;
    skip_d    = skip_q;
    ovs_d     = ovs_q;
    cur_d     = cur_q;
    fidx_d    = fidx_q;
    acc_d     = acc_q;
    cs_n_d    = cs_n_q;
    div_num_d = div_num_q;
    res_d     = res_q;
    go_d      = 1'b0;
    div_go_d  = 1'b0;
    vld_d     = '0;
    done_d    = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          mask_d = ch_en;
          skip_d = skip_cnt;
          ovs_d  = ovs_cnt;
          if (found_all) begin
            cur_d  = idx_all;
            cs_n_d = 1'b0;
            st_d   = SQ_LOAD;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      SQ_LOAD: begin
        fidx_d = '0;
        acc_d  = '0;
        go_d   = 1'b1;
        st_d   = SQ_XFER;
      end
      SQ_XFER: begin
        if (frm_done) begin
          acc_d = acc_sum;
          if (last_fr) begin
            div_go_d  = 1'b1;
            div_num_d = acc_sum;
            st_d      = SQ_DIV;
            if (!found_hi) cs_n_d = 1'b1;
          end else begin
            fidx_d = fidx_q + 1'b1;
            go_d   = 1'b1;
          end
        end
      end
      SQ_DIV: begin
        if (div_done) begin
          res_d[cur_q*RES_W +: RES_W] = div_quo[RES_W-1:0];
          vld_d[cur_q] = 1'b1;
          if (found_hi) begin
            cur_d = idx_hi;
            st_d  = SQ_LOAD;
          end else begin
            done_d = 1'b1;
            st_d   = SQ_IDLE;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      mask_q    <= '0;
      skip_q    <= '0;
      ovs_q     <= '0;
      cur_q     <= '0;
      fidx_q    <= '0;
      acc_q     <= '0;
      go_q      <= 1'b0;
      cs_n_q    <= 1'b1;
      div_go_q  <= 1'b0;
      div_num_q <= '0;
      res_q     <= '0;
      vld_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      mask_q    <= mask_d;
      skip_q    <= skip_d;
      ovs_q     <= ovs_d;
      cur_q     <= cur_d;
      fidx_q    <= fidx_d;
      acc_q     <= acc_d;
      go_q      <= go_d;
      cs_n_q    <= cs_n_d;
      div_go_q  <= div_go_d;
      div_num_q <= div_num_d;
      res_q     <= res_d;
      vld_q     <= vld_d;
      done_q    <= done_d;
    end
  end

  assign spi_cs_n   = cs_n_q;
  assign result     = res_q;
  assign result_vld = vld_q;
  assign done       = done_q;

endmodule

// File: rtl/tsc_scan_seq_chk.sv
module tsc_scan_seq_chk #(
  parameter int NCH   = 8,
  parameter int RES_W = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 spi_sclk,
  input logic                 spi_cs_n,
  input logic [NCH*RES_W-1:0] result,
  input logic [NCH-1:0]       result_vld,
  input logic                 done,
  input logic [NCH-1:0]       mask_q,
  input logic                 frm_active,
  input logic                 go,
  input logic [7:0]           cmd
);

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R8

  AST_CS_LOW_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frm_active |-> !spi_cs_n); // R8

  AST_CMD_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (cmd[7] && !cmd[3] && (cmd[2] == cmd[1]))); // R1

  AST_VLD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(result_vld)); // R6

  AST_VLD_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (result_vld & ~mask_q) == '0); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done); // R7

  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n); // R7

  for (genvar g = 0; g < NCH; g++) begin : g_hold
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !result_vld[g] |-> $stable(result[g*RES_W +: RES_W])); // R6
  end

endmodule

bind tsc_scan_seq tsc_scan_seq_chk #(.NCH(NCH), .RES_W(12)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .spi_sclk   (spi_sclk),
  .spi_cs_n   (spi_cs_n),
  .result     (result),
  .result_vld (result_vld),
  .done       (done),
  .mask_q     (mask_q),
  .frm_active (frm_active),
  .go         (go_q),
  .cmd        (frm_cmd)
);

// File: tb/tsc_scan_seq_test.sv
module tsc_scan_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 8;
  localparam int CW   = 2;
  localparam int HALF = 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [NCH-1:0]    ch_en = '0;
  logic [NCH*CW-1:0] skip_cnt = '0;
  logic [NCH*CW-1:0] ovs_cnt = '0;
  logic              spi_sclk, spi_cs_n, spi_mosi;
  logic              spi_miso = 1'b0;
  logic [NCH*12-1:0] result;
  logic [NCH-1:0]    result_vld;
  logic              done;

  tsc_scan_seq #(.NCH(NCH), .CNT_W(CW), .SCLK_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ch_en(ch_en),
    .skip_cnt(skip_cnt), .ovs_cnt(ovs_cnt),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .result(result), .result_vld(result_vld), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // scan configuration
  logic [NCH-1:0] cfg_mask;
  int cfg_skip [NCH];
  int cfg_ovs  [NCH];
  int cur_id;
  int prev_res [NCH];

  // converter model state
  logic [7:0]  log_cmd [0:255];
  int          fr_cnt, bitc, prev_addr, gf, sl_addr;
  logic [7:0]  csh;
  logic [15:0] word;
  int          cs_rise, fr_at_rise, bad_rise;

  // collected outputs
  int          vcnt [NCH];
  int          vres [NCH];
  logic [NCH-1:0] vld_at_done;
  int          cycles_to_done;
  bit          cs_went_low;
  bit          timed_out;

  function automatic logic [11:0] smp(input int id, input int ch, input int f);
    int v;
    if (id % 5 == 0) v = 4095 - f;
    else v = (id * 211 + ch * 523 + f * 97 + 5) % 4096;
    return 12'(v);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // converter model: capture command, return reply MSB first
  always @(posedge spi_sclk) begin
    if (spi_cs_n) bad_rise++;
    else begin
      if (bitc < 8) csh = {csh[6:0], spi_mosi};
      if (bitc == 7) begin
        sl_addr = int'(csh[6:4]);
        if (fr_cnt == 0 || sl_addr != prev_addr) gf = 0;
        else gf++;
        prev_addr = sl_addr;
        if (fr_cnt < 256) log_cmd[fr_cnt] = csh;
        word = {1'b0, smp(cur_id, sl_addr, gf), 3'b000};
      end
      bitc++;
      if (bitc == 24) begin
        bitc = 0;
        fr_cnt++;
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n && bitc >= 8) spi_miso = word[23 - bitc];
    else spi_miso = 1'b0;
  end

  always @(posedge spi_cs_n) begin
    if (rst_n) begin
      cs_rise++;
      fr_at_rise = fr_cnt;
    end
  end

  task automatic launch();
    ch_en = cfg_mask;
    for (int i = 0; i < NCH; i++) begin
      skip_cnt[i*CW +: CW] = CW'(cfg_skip[i]);
      ovs_cnt[i*CW +: CW]  = CW'(cfg_ovs[i]);
    end
    fr_cnt = 0;
    bitc = 0;
    prev_addr = -1;
    cs_rise = 0;
    bad_rise = 0;
    start = 1'b1;
  endtask

  task automatic collect(input bit stray);
    int n;
    n = 0;
    cs_went_low = 0;
    timed_out = 0;
    vld_at_done = '0;
    for (int i = 0; i < NCH; i++) begin
      vcnt[i] = 0;
      vres[i] = 0;
    end
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) start = 1'b0;
      if (stray && n == 20) begin
        start = 1'b1;
        ch_en = ~cfg_mask;
      end
      if (stray && n == 21) begin
        start = 1'b0;
        ch_en = cfg_mask;
      end
      if (!spi_cs_n) cs_went_low = 1;
      for (int i = 0; i < NCH; i++) begin
        if (result_vld[i]) begin
          vcnt[i]++;
          vres[i] = int'(result[i*12 +: 12]);
        end
      end
      if (done) begin
        vld_at_done = result_vld;
        break;
      end
      if (n > 6000) begin
        timed_out = 1;
        break;
      end
    end
    cycles_to_done = n;
  endtask

  task automatic judge(input string tag_sc);
    int ef, ov, nf, hi;
    longint sum, expv;
    logic [7:0] ec;
    logic r;
    ef = 0;
    hi = -1;
    chk(!timed_out, "R7", "done seen", timed_out, 0);
    for (int c = 0; c < NCH; c++) begin
      if (cfg_mask[c]) begin
        hi = c;
        ov = (cfg_ovs[c] == 0) ? 1 : cfg_ovs[c];
        nf = cfg_skip[c] + ov;
        sum = 0;
        for (int f = 0; f < nf; f++) begin
          r = (c == 0) || (c == 2) || (c == 6) || (c == 7);
          ec = {1'b1, 3'(c), 1'b0, r, r, (f != nf - 1)};
          if (ef < fr_cnt && ef < 256) begin
            chk(log_cmd[ef][7:1] == ec[7:1], "R1", "command upper bits",
                log_cmd[ef], ec);
            chk(log_cmd[ef][0] == ec[0], "R2", "power-keep bit",
                log_cmd[ef][0], ec[0]);
          end
          if (f >= cfg_skip[c]) sum += smp(cur_id, c, f);
          ef++;
        end
        expv = (sum + ov - 1) / ov;
        chk(vcnt[c] == 1, "R6", "strobe count enabled", vcnt[c], 1);
        chk(vres[c] == expv, (cfg_ovs[c] == 0) ? "R5" : "R4", "average",
            vres[c], expv);
        prev_res[c] = int'(expv);
      end else begin
        chk(vcnt[c] == 0, "R6", "strobe count disabled", vcnt[c], 0);
        chk(int'(result[c*12 +: 12]) == prev_res[c], "R6", "disabled slot held",
            result[c*12 +: 12], prev_res[c]);
      end
    end
    chk(fr_cnt == ef, tag_sc, "frame count", fr_cnt, ef);
    chk(bad_rise == 0, "R8", "sclk edge with cs high", bad_rise, 0);
    if (cfg_mask == '0) begin
      chk(cycles_to_done == 1, "R7", "empty mask done latency", cycles_to_done, 1);
      chk(!cs_went_low && cs_rise == 0, "R7", "empty mask cs idle", cs_went_low, 0);
    end else begin
      chk(cs_rise == 1, "R8", "cs release count", cs_rise, 1);
      chk(fr_at_rise == ef, "R8", "cs released after last frame", fr_at_rise, ef);
      chk(vld_at_done == (NCH'(1) << hi), "R7", "done with last strobe",
          vld_at_done, NCH'(1) << hi);
      chk(spi_cs_n == 1'b1, "R7", "cs high at done", spi_cs_n, 1);
    end
  endtask

  initial begin
    bit b2b;
    for (int i = 0; i < NCH; i++) prev_res[i] = 0;
    cur_id = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(spi_cs_n == 1'b1, "R10", "cs_n after reset", spi_cs_n, 1);
    chk(spi_sclk == 1'b0 && spi_mosi == 1'b0, "R10", "sclk/mosi after reset",
        {spi_sclk, spi_mosi}, 0);
    chk(done == 1'b0 && result_vld == '0, "R10", "done/valid after reset",
        {done, result_vld}, 0);
    chk(result == '0, "R10", "results after reset", result[11:0], 0);

    // mask sweep; every scan after an even one starts in the done cycle
    b2b = 0;
    for (int k = 0; k < 64; k++) begin
      cur_id = k;
      cfg_mask = NCH'((k * 4) | (k & 3));
      for (int i = 0; i < NCH; i++) begin
        cfg_skip[i] = (k + i) % 4;
        cfg_ovs[i]  = (k * 3 + i * 2) % 4;
      end
      launch();
      collect(cfg_mask != '0 && (k % 3 == 1));
      judge(b2b ? "R9" : "R3");
      b2b = (k % 2 == 0);
      if (!b2b) repeat (3) @(negedge clk);
    end
    if (b2b) repeat (3) @(negedge clk);

    // exhaustive settling/averaging pairs on a single channel
    for (int c = 0; c < 16; c++) begin
      cur_id = 100 + c;
      cfg_mask = NCH'(1) << ((c * 3) % 8);
      for (int i = 0; i < NCH; i++) begin
        cfg_skip[i] = c / 4;
        cfg_ovs[i]  = c % 4;
      end
      launch();
      collect(1'b0);
      judge("R3");
      repeat (3) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule